// File: doc/BRIEF.md
# Table-Driven Input Mixing Sequencer for the Gascon Permutation

This block takes a 320-bit permutation state, a 128-bit message block, a 4-bit domain separator and a 128-bit secret table. It folds the 132 absorbed bits into the state, one chunk at a time. Each 2-bit group of a chunk never enters the state itself. It acts as an index that picks one of four 32-bit table words, and that word is xored into the low half of one lane. A single permutation round with the fixed constant 0xF0 separates consecutive chunks. After the last chunk, a full permutation of the requested length runs and folds its output into a 128-bit accumulator. Both results are then presented to the surrounding hash or AEAD datapath.

All operands are captured on the start cycle. The sequencer then runs on its own, one operation per clock: a mixing step, a single round, or one round of the final permutation. It raises `done` for one cycle when the final permutation finishes and holds the results until the next accepted start.

Top module: `gascon_mix_seq`

## Requirements
- R1: After reset, `state_out` and `racc_out` are all zero and `done` is low.
- R2: A `start` seen while idle captures `blk_in`, `dsep_in`, `xtab_in`, `rounds_in` and `state_in`, loads the working state from `state_in`, and clears the accumulator. Input changes after that edge have no effect on the result.
- R3: Table word k is `xtab_in[32k+31:32k]`. Within a 10-bit chunk, bits [2i+1:2i] select the word that is xored into bits [31:0] of lane i (lane i is `state_in[64i+63:64i]`). The upper 32 bits of every lane are left alone by mixing.
- R4: The absorbed stream is bit i = `blk_in[i]` for i < 128, followed by bit 128+j = `dsep_in[j]`. Chunk s (s = 0..12) is stream bits 10s..10s+9, so chunk 12 carries `blk_in[127:120]` and `dsep_in[1:0]`. Step 13 uses `dsep_in[3:2]` to select a word for lane 0 only.
- R5: Exactly one round with constant 0xF0 follows each of the chunk steps 0..12. No round follows step 13. The accumulator stays zero during this phase.
- R6: A round xors its constant into bits [7:0] of lane 2 and then applies the 5-bit S-box bitwise across lanes. The S-box does the following in order: a0^=a4, a4^=a3, a2^=a1; then chi with b_k = a_k ^ (~a_{k+1} & a_{k+2}) taken mod 5; then b1^=b0, b0^=b4, b3^=b2, b2=~b2. Next, each lane is xored with two right rotations of itself: lane 0 by 19 and 28, lane 1 by 61 and 38, lane 2 by 1 and 6, lane 3 by 10 and 17, lane 4 by 7 and 40.
- R7: After step 13, N = `rounds_in` (1 to 12) rounds run. Round k uses j = 12-N+k and constant ((4+j)<<4)|(11-j), so the last constant is 0xF0. After each round, accumulator word m (bits 32m+31:32m) is xored with state words m and 4+((m+1) mod 4), where state word w is `state_out[32w+31:32w]`.
- R8: `done` is high for exactly one cycle, on the 27+N-th rising edge after the edge that accepted `start`. `state_out` and `racc_out` then hold the final results unchanged until the next accepted start.
- R9: `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| blk_in | input | 128 | Message block to absorb |
| dsep_in | input | 4 | Domain separator |
| xtab_in | input | 128 | Secret table of four 32-bit words |
| rounds_in | input | 4 | Final permutation length, 1 to 12 |
| state_in | input | 320 | Initial five-lane state |
| state_out | output | 320 | Working or final five-lane state |
| racc_out | output | 128 | Round accumulator |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each operation makes its results due on exactly the 27+N-th rising edge after the accepting edge. That count is 14 mixing steps, 13 single rounds and N final rounds, one per clock. The bench counts falling edges from the accepting edge. It requires `done` low on every one of them before that point and high on that one. It compares both result buses against its behavioural model only there, then checks that they stay frozen on the following idle cycles. Stray `start` pulses in the middle of a run and operand changes after acceptance are made so that any effect would show up in the compared results.

// File: rtl/gascon_mix_pkg.sv
package gascon_mix_pkg;
   localparam int LANES    = 5;
   localparam int LANE_W   = 64;
   localparam int HALF_W   = LANE_W / 2;
   localparam int XSEL_W   = 2;
   localparam int XWORDS   = 1 << XSEL_W;
   localparam int XTAB_W   = XWORDS * HALF_W;
   localparam int STATE_W  = LANES * LANE_W;
   localparam int RACC_NW  = 4;
   localparam int RACC_W   = RACC_NW * HALF_W;
   localparam int RC_SLOTS = 12;

   typedef logic [LANE_W-1:0] lane_t;
   typedef lane_t [LANES-1:0] cstate_t;

   typedef enum logic [1:0] {PH_IDLE, PH_MIX, PH_RND, PH_FIN} phase_e;

   localparam logic [7:0] RC_MIX = 8'hF0;

   function automatic lane_t rotr(lane_t v, int n);
      return (v >> n) | (v << (LANE_W - n));
   endfunction

   function automatic int rot_lo(int lane);
      case (lane)
         0: return 19;
         1: return 61;
         2: return 1;
         3: return 10;
         default: return 7;
      endcase
   endfunction

   function automatic int rot_hi(int lane);
      case (lane)
         0: return 28;
         1: return 38;
         2: return 6;
         3: return 17;
         default: return 40;
      endcase
   endfunction

   // slot j gives ((4+j)<<4)|(11-j); the last slot is 0xF0
   function automatic logic [7:0] rc_of(logic [3:0] j);
      return {4'(4 + int'(j)), 4'(RC_SLOTS - 1 - int'(j))};
   endfunction
endpackage

// File: rtl/gascon_round.sv
module gascon_round
   import gascon_mix_pkg::*;
(
   input  cstate_t    c_i,
   input  logic [7:0] rc_i,
   output cstate_t    c_o
);
   cstate_t s;
   lane_t   x0, x1, x2, x3, x4;

   always_comb begin
      x0   = c_i[0] ^ c_i[4];
      x1   = c_i[1];
      x2   = c_i[2] ^ LANE_W'(rc_i) ^ c_i[1];
      x3   = c_i[3];
      x4   = c_i[4] ^ c_i[3];
      s[4] = x4 ^ (~x0 & x1);
      s[0] = x0 ^ (~x1 & x2) ^ s[4];
      s[1] = x1 ^ (~x2 & x3) ^ x0 ^ (~x1 & x2);
      s[2] = ~(x2 ^ (~x3 & x4));
      s[3] = x3 ^ (~x4 & x0) ^ x2 ^ (~x3 & x4);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_diff
      assign c_o[g] = s[g] ^ rotr(s[g], rot_lo(g)) ^ rotr(s[g], rot_hi(g));
   end
endmodule

// File: rtl/gascon_xinject.sv
module gascon_xinject
   import gascon_mix_pkg::*;
(
   input  cstate_t                  c_i,
   input  logic [2*LANES-1:0]       chunk_i,
   input  logic [LANES-1:0]         lane_en_i,
   input  logic [XTAB_W-1:0]        xtab_i,
   output cstate_t                  c_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [XSEL_W-1:0] sel;
      logic [HALF_W-1:0] word;
      assign sel  = chunk_i[XSEL_W*g +: XSEL_W];
      assign word = xtab_i[int'(sel)*HALF_W +: HALF_W];
      assign c_o[g] = lane_en_i[g] ? {c_i[g][LANE_W-1:HALF_W], c_i[g][HALF_W-1:0] ^ word}
                                   : c_i[g];
   end
endmodule

// File: rtl/gascon_racc.sv
module gascon_racc
   import gascon_mix_pkg::*;
(
   input  logic [RACC_W-1:0] r_i,
   input  cstate_t           c_i,
   output logic [RACC_W-1:0] r_o
);
   for (genvar m = 0; m < RACC_NW; m++) begin : g_word
      localparam int WA = m;
      localparam int WB = RACC_NW + ((m + 1) % RACC_NW);
      assign r_o[m*HALF_W +: HALF_W] = r_i[m*HALF_W +: HALF_W]
                                     ^ c_i[WA/2][(WA%2)*HALF_W +: HALF_W]
                                     ^ c_i[WB/2][(WB%2)*HALF_W +: HALF_W];
   end
endmodule

// File: rtl/gascon_mix_seq.sv
module gascon_mix_seq
   import gascon_mix_pkg::*;
#(
   parameter int IN_W  = 128,
   parameter int DS_W  = 4,
   parameter int RND_W = 4
)
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [IN_W-1:0]    blk_in,
   input  logic [DS_W-1:0]    dsep_in,
   input  logic [XTAB_W-1:0]  xtab_in,
   input  logic [RND_W-1:0]   rounds_in,
   input  logic [STATE_W-1:0] state_in,
   output logic [STATE_W-1:0] state_out,
   output logic [RACC_W-1:0]  racc_out,
   output logic               done
);
   localparam int TOT_W   = IN_W + DS_W;
   localparam int STEP_W  = 2 * LANES;
   localparam int N_FULL  = TOT_W / STEP_W;
   localparam int REM     = TOT_W % STEP_W;
   localparam int N_STEPS = N_FULL + ((REM > 0) ? 1 : 0);
   localparam int LAST    = N_STEPS - 1;
   localparam int IDX_W   = $clog2(N_STEPS);
   localparam int PAD_W   = N_STEPS * STEP_W;

   function automatic logic [LANES-1:0] tail_mask(int rem);
      logic [LANES-1:0] m;
      for (int g = 0; g < LANES; g++) m[g] = (rem == 0) || (2 * g < rem);
      return m;
   endfunction
   localparam logic [LANES-1:0] TAIL_EN = tail_mask(REM);

   if (REM % 2 != 0) begin : g_bad_rem
      $error("absorbed width must leave an even tail");
   end
   if (RND_W < $clog2(RC_SLOTS + 1)) begin : g_bad_rnd
      $error("round count port too narrow");
   end

   cstate_t             c_q, inj_c, rnd_c;
   logic [RACC_W-1:0]   r_q, r_nxt;
   logic [IN_W-1:0]     blk_q;
   logic [DS_W-1:0]     ds_q;
   logic [XTAB_W-1:0]   xtab_q;
   logic [RND_W-1:0]    rounds_q;
   phase_e              phase_q;
   logic [IDX_W-1:0]    idx_q;
   logic [3:0]          rcj_q;
   logic                done_q;
   logic [PAD_W-1:0]    padded;
   logic [STEP_W-1:0]   chunk;
   logic [LANES-1:0]    lane_en;
   logic [7:0]          rnd_rc;

   assign padded  = PAD_W'({ds_q, blk_q});
   assign chunk   = padded[int'(idx_q)*STEP_W +: STEP_W];
   assign lane_en = (idx_q == IDX_W'(LAST)) ? TAIL_EN : '1;
   assign rnd_rc  = (phase_q == PH_FIN) ? rc_of(rcj_q) : RC_MIX;

   gascon_xinject u_inj (
      .c_i       (c_q),
      .chunk_i   (chunk),
      .lane_en_i (lane_en),
      .xtab_i    (xtab_q),
      .c_o       (inj_c)
   );

   gascon_round u_rnd (
      .c_i  (c_q),
      .rc_i (rnd_rc),
      .c_o  (rnd_c)
   );

   gascon_racc u_acc (
      .r_i (r_q),
      .c_i (rnd_c),
      .r_o (r_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q      <= '0;
         r_q      <= '0;
         blk_q    <= '0;
         ds_q     <= '0;
         xtab_q   <= '0;
         rounds_q <= '0;
         phase_q  <= PH_IDLE;
         idx_q    <= '0;
         rcj_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  c_q      <= state_in;
                  r_q      <= '0;
                  blk_q    <= blk_in;
                  ds_q     <= dsep_in;
                  xtab_q   <= xtab_in;
                  rounds_q <= rounds_in;
                  idx_q    <= '0;
                  phase_q  <= PH_MIX;
               end
            end
            PH_MIX: begin
               c_q <= inj_c;
               if (idx_q == IDX_W'(LAST)) begin
                  rcj_q   <= 4'(RC_SLOTS - int'(rounds_q));
                  phase_q <= PH_FIN;
               end else begin
                  phase_q <= PH_RND;
               end
            end
            PH_RND: begin
               c_q     <= rnd_c;
               idx_q   <= idx_q + 1'b1;
               phase_q <= PH_MIX;
            end
            PH_FIN: begin
               c_q <= rnd_c;
               r_q <= r_nxt;
               if (rcj_q == 4'(RC_SLOTS - 1)) begin
                  done_q  <= 1'b1;
                  phase_q <= PH_IDLE;
               end else begin
                  rcj_q <= rcj_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign state_out = c_q;
   assign racc_out  = r_q;
   assign done      = done_q;
endmodule

// File: rtl/gascon_mix_seq_chk.sv
module gascon_mix_seq_chk
   import gascon_mix_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int RND_W = 4,
   parameter int LAST  = 13
)
(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input phase_e            phase,
   input logic [IDX_W-1:0]  idx,
   input logic [RACC_W-1:0] racc,
   input logic [RND_W-1:0]  rounds_q
);
   localparam int LAT_BASE = 2 * LAST + 1;
   localparam int CNT_W    = $clog2(LAT_BASE + (1 << RND_W) + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (phase == PH_IDLE && start)  cnt <= '0;
      else if (phase != PH_IDLE)           cnt <= cnt + 1'b1;
   end

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start) |=> (phase == PH_MIX && idx == '0 && racc == '0));

   assert_tail_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MIX && idx == IDX_W'(LAST)) |=> (phase == PH_FIN));

   assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_W'(LAST));

   assert_racc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MIX || phase == PH_RND) |-> racc == '0);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cnt == CNT_W'(LAT_BASE) + CNT_W'(rounds_q)));

   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(rounds_q));
endmodule

bind gascon_mix_seq gascon_mix_seq_chk #(
   .IDX_W (IDX_W),
   .RND_W (RND_W),
   .LAST  (LAST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .done     (done),
   .phase    (phase_q),
   .idx      (idx_q),
   .racc     (racc_out),
   .rounds_q (rounds_q)
);

// File: tb/gascon_mix_seq_test.sv
`timescale 1ns/1ps
module gascon_mix_seq_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [127:0] blk_in;
   logic [3:0]   dsep_in;
   logic [127:0] xtab_in;
   logic [3:0]   rounds_in;
   logic [319:0] state_in;
   logic [319:0] state_out;
   logic [127:0] racc_out;
   logic         done;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   gascon_mix_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .blk_in    (blk_in),
      .dsep_in   (dsep_in),
      .xtab_in   (xtab_in),
      .rounds_in (rounds_in),
      .state_in  (state_in),
      .state_out (state_out),
      .racc_out  (racc_out),
      .done      (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [319:0] act, input logic [319:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rr(input logic [63:0] v, input int n);
      logic [127:0] d;
      d = {v, v} >> n;
      return d[63:0];
   endfunction

   // behavioural round, per bit column (R6)
   function automatic logic [319:0] m_round(input logic [319:0] s, input logic [7:0] rc);
      logic [63:0] l [5];
      int ra [5] = '{19, 61, 1, 10, 7};
      int rb [5] = '{28, 38, 6, 17, 40};
      for (int k = 0; k < 5; k++) l[k] = s[64*k +: 64];
      l[2][7:0] = l[2][7:0] ^ rc;
      for (int b = 0; b < 64; b++) begin
         logic [4:0] a, y;
         for (int k = 0; k < 5; k++) a[k] = l[k][b];
         a[0] ^= a[4]; a[4] ^= a[3]; a[2] ^= a[1];
         for (int k = 0; k < 5; k++) y[k] = a[k] ^ (~a[(k+1)%5] & a[(k+2)%5]);
         y[1] ^= y[0]; y[0] ^= y[4]; y[3] ^= y[2]; y[2] = ~y[2];
         for (int k = 0; k < 5; k++) l[k][b] = y[k];
      end
      for (int k = 0; k < 5; k++) l[k] = l[k] ^ rr(l[k], ra[k]) ^ rr(l[k], rb[k]);
      for (int k = 0; k < 5; k++) s[64*k +: 64] = l[k];
      return s;
   endfunction

   task automatic model(input logic [127:0] bi, input logic [3:0] ds, input logic [127:0] xt,
                        input int n, input logic [319:0] st,
                        output logic [319:0] es, output logic [127:0] er);
      logic [131:0] bits;
      bits = {ds, bi};
      es = st;
      for (int step = 0; step < 14; step++) begin
         for (int ln = 0; ln < 5; ln++) begin
            if (step < 13 || ln == 0) begin
               int sel;
               sel = int'(bits[10*step + 2*ln +: 2]);
               es[64*ln +: 32] = es[64*ln +: 32] ^ xt[32*sel +: 32];
            end
         end
         if (step < 13) es = m_round(es, 8'hF0);
      end
      er = '0;
      for (int k = 0; k < n; k++) begin
         int j;
         j  = 12 - n + k;
         es = m_round(es, 8'(((4 + j) << 4) | (11 - j)));
         for (int m = 0; m < 4; m++)
            er[32*m +: 32] = er[32*m +: 32] ^ es[32*m +: 32] ^ es[32*(4 + ((m+1)%4)) +: 32];
      end
   endtask

   function automatic logic [319:0] rnd320();
      logic [319:0] v;
      for (int w = 0; w < 10; w++) v[32*w +: 32] = $urandom;
      return v;
   endfunction

   // starts at a falling edge, returns at the falling edge where done is due
   task automatic run_op(input logic [127:0] bi, input logic [3:0] ds, input logic [127:0] xt,
                         input int n, input logic [319:0] st, input bit poke, input string tag);
      logic [319:0] es;
      logic [127:0] er;
      int lat;
      model(bi, ds, xt, n, st, es, er);
      lat = 2*13 + 1 + n;
      blk_in = bi; dsep_in = ds; xtab_in = xt; rounds_in = 4'(n); state_in = st;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      blk_in = ~bi; dsep_in = ~ds; xtab_in = ~xt; state_in = ~st;
      rounds_in = (n == 12) ? 4'd1 : 4'd12;
      chk(done === 1'b0, "R8", "done after accept", 320'(done), 320'(0));
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         start = poke && (k == 4);
         chk(done === (k == lat), "R8", $sformatf("done at cycle %0d", k), 320'(done), 320'(k == lat));
         if (k == lat) begin
            chk(state_out === es, tag, "state_out", state_out, es);
            chk(racc_out === er, tag, "racc_out", 320'(racc_out), 320'(er));
         end
      end
      start = 1'b0;
   endtask

   initial begin
      #(20ns * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [127:0] b0, x0;
      logic [319:0] s0, so;
      logic [127:0] ro;
      rst_n = 1'b0; start = 1'b0; blk_in = '0; dsep_in = '0; xtab_in = '0;
      rounds_in = '0; state_in = '0;
      repeat (3) @(negedge clk);
      chk(state_out === '0, "R1", "reset state_out", state_out, '0);
      chk(racc_out === '0, "R1", "reset racc_out", 320'(racc_out), '0);
      chk(done === 1'b0, "R1", "reset done", 320'(done), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: an all-zero table leaves only the rounds acting
      run_op(128'h0123456789abcdef_fedcba9876543210, 4'hA, '0, 12, rnd320(), 1'b0, "R3");
      // R3: distinct table words, all-zero state and block
      run_op('0, 4'h0, 128'h44444444_33333333_22222222_11111111, 12, '0, 1'b0, "R3 R6");
      // R5 R6: random operands, full length
      b0 = {$urandom, $urandom, $urandom, $urandom};
      x0 = {$urandom, $urandom, $urandom, $urandom};
      s0 = rnd320();
      run_op(b0, 4'h5, x0, 12, s0, 1'b0, "R5 R6");
      // R4: separator high bits alone differ
      run_op(b0, 4'h1, x0, 8, s0, 1'b0, "R4");
      run_op(b0, 4'hD, x0, 8, s0, 1'b0, "R4");
      // R4: top message byte and separator low bits share chunk 12
      run_op({8'hFF, 120'h0}, 4'h3, x0, 3, '0, 1'b0, "R4");
      // R7: shortest and mid-length final permutations
      run_op(b0, 4'h7, x0, 1, s0, 1'b0, "R7");
      run_op(~b0, 4'h9, ~x0, 5, ~s0, 1'b0, "R7");
      // R9: start pulse in the middle of a run
      run_op(b0, 4'hC, x0, 7, s0, 1'b1, "R9");
      // R2: back-to-back start right on the done cycle, accumulator must restart at zero
      run_op(~b0, 4'h2, x0, 12, rnd320(), 1'b0, "R2");
      // R8: results held while idle
      so = state_out;
      ro = racc_out;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(done === 1'b0, "R8", "done idle", 320'(done), '0);
         chk(state_out === so && racc_out === ro, "R8", "hold state_out", state_out, so);
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule